// File: doc/BRIEF.md
# Prioritized Interrupt Masking Arbiter

This block decides which single pending interrupt, if any, a processor core should take on the next clock. It has eight sources: three physical ones (non-maskable, fast and normal interrupt) and five virtual ones (virtual non-maskable, virtual fast non-maskable, virtual normal, virtual fast and virtual system error). For each source it evaluates the masking rules. Those rules depend on the current privilege level, the security state, the hypervisor and secure-monitor routing controls, the processor mask bits and the execution width. It then applies a fixed priority and registers the winner's exception index and target privilege level.

Targets for the physical sources are computed elsewhere and arrive as inputs. Every virtual source targets level 1. When the non-maskable feature is switched off at the current level, each superpriority request is demoted into its ordinary counterpart before arbitration.

Top module: `irq_take_arbiter`

## Requirements
- R1: No exception is taken whose target level is below the current level.
- R2: The all-interrupt mask for a source is active only when the non-maskable feature is enabled for that source's target level and the current level equals that target. It is then set by the all-mask bit, or by the per-level stack-mask enable together with the stack-select bit.
- R3: The physical non-maskable source is blocked only by the all-interrupt mask. The fast source is blocked by the F bit or the all-interrupt mask. The normal source is blocked by the I bit or the all-interrupt mask.
- R4: With the trap-general control set, every virtual source is refused. Otherwise the virtual normal and virtual non-maskable sources need the IRQ-routing control, the virtual fast and virtual fast non-maskable sources need the FIQ-routing control, and the virtual error needs the abort-routing control.
- R5: The virtual error is blocked only by the A bit and ignores the all-interrupt mask. The virtual non-maskable and virtual fast non-maskable sources are blocked only by the all-interrupt mask. The virtual normal source is blocked by I plus the all-interrupt mask, and the virtual fast source by F plus the all-interrupt mask. All virtual sources target level 1.
- R6: In 64-bit mode, a physical source whose target is above the current level and is not 1 ignores its mask bits. For a target of 3 this always holds. For a target of 2 it holds unless the host-extension and trap-general controls are both set. A target of 1 never gets this override.
- R7: In 32-bit mode, under the same target condition, a non-secure fast interrupt ignores its mask when the FIQ-routing control is set. It also ignores its mask when the monitor FIQ-route bit is set, unless the monitor FW bit is set while the FIQ-routing control is clear. A non-secure normal interrupt ignores its mask only when the IRQ-routing control is set. In secure state there is no override.
- R8: Request bit k and exception index k share one encoding: 0 non-maskable, 1 virtual non-maskable, 2 virtual fast non-maskable, 3 fast, 4 normal, 5 virtual normal, 6 virtual fast, 7 virtual error. Among unblocked sources the lowest index wins.
- R9: When the non-maskable enable for the current level is clear, request 0 counts as request 4, request 1 as request 5 and request 2 as request 6, so indices 0 to 2 are never produced.
- R10: Reset clears the take flag, index and target to zero. A winner found from the inputs present before a rising edge appears on the outputs after that edge, and the take flag is high for exactly that cycle.
- R11: When no source is unblocked, the take flag is low and the index and target keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Pending requests, bit k = exception index k |
| cur_lvl_i | input | 2 | Current privilege level |
| secure_i | input | 1 | Secure state |
| hv_imo_i | input | 1 | Hypervisor IRQ routing |
| hv_fmo_i | input | 1 | Hypervisor FIQ routing |
| hv_amo_i | input | 1 | Hypervisor abort routing |
| hv_tge_i | input | 1 | Hypervisor trap-general |
| hv_e2h_i | input | 1 | Hypervisor host extension |
| mon_fiq_route_i | input | 1 | Monitor routes FIQ upward |
| mon_fw_i | input | 1 | Monitor allows F to mask non-secure FIQ |
| mask_irq_i | input | 1 | I mask bit |
| mask_fiq_i | input | 1 | F mask bit |
| mask_abt_i | input | 1 | A mask bit |
| mask_all_i | input | 1 | All-interrupt mask bit |
| sp_sel_i | input | 1 | Stack-select bit |
| nmi_en_i | input | 4 | Non-maskable feature enable per level |
| spmask_en_i | input | 4 | Stack-based interrupt mask enable per level |
| mode64_i | input | 1 | 1 = 64-bit execution mode |
| tgt_nmi_i | input | 2 | Target level of physical non-maskable |
| tgt_fiq_i | input | 2 | Target level of fast interrupt |
| tgt_irq_i | input | 2 | Target level of normal interrupt |
| take_o | output | 1 | Exception taken this cycle |
| exc_idx_o | output | 3 | Taken exception index |
| exc_tgt_o | output | 2 | Taken target level |

## Verification
The decision path is combinational up to one output register, so every result is due on the rising edge that follows the falling edge at which the driver applied the stimulus. The driver applies each vector on a falling edge and queues its expected take flag, index and target at the same moment. The monitor pops exactly one entry 1 ns after each rising edge, so each comparison lands one register stage after its stimulus and before the next vector is applied. For vectors where nothing should be taken, the queued index and target are the last ones taken, which checks the hold behaviour directly at the ports.

// File: rtl/irq_arb_pkg.sv
// Package: shared encodings for the interrupt take arbiter.
// Assumes an 8-source set whose index order is also the priority order.
package irq_arb_pkg;
    localparam int NUM_SRC = 8;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [IDX_W-1:0] {
        EX_NMI   = 3'd0,
        EX_VNMI  = 3'd1,
        EX_VFNMI = 3'd2,
        EX_FIQ   = 3'd3,
        EX_IRQ   = 3'd4,
        EX_VIRQ  = 3'd5,
        EX_VFIQ  = 3'd6,
        EX_VSERR = 3'd7
    } exc_e;
endpackage

// File: rtl/irq_fold.sv
// Module: irq_fold
// Demotes superpriority requests into their ordinary counterparts when the
// non-maskable feature is off at the current level. Purely combinational.
module irq_fold
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               nmi_on_i,
    output logic [NUM_SRC-1:0] eff_o
);
    // Merge or pass the request vector depending on the feature enable.
    always_comb begin
        eff_o = req_i;
        if (!nmi_on_i) begin
            eff_o[EX_IRQ]   = req_i[EX_IRQ]  | req_i[EX_NMI];
            eff_o[EX_VIRQ]  = req_i[EX_VIRQ] | req_i[EX_VNMI];
            eff_o[EX_VFIQ]  = req_i[EX_VFIQ] | req_i[EX_VFNMI];
            eff_o[EX_NMI]   = 1'b0;
            eff_o[EX_VNMI]  = 1'b0;
            eff_o[EX_VFNMI] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_eval.sv
// Module: irq_mask_eval
// Applies the per-source masking rules and returns which pending sources may
// be taken. Assumes targets are already resolved per source.
module irq_mask_eval
    import irq_arb_pkg::*;
#(
    parameter int LVL_W = 2,
    localparam int LVLS = 1 << LVL_W
) (
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] tgt_i,
    input  logic [LVL_W-1:0]              cur_i,
    input  logic                          secure_i,
    input  logic                          imo_i,
    input  logic                          fmo_i,
    input  logic                          amo_i,
    input  logic                          tge_i,
    input  logic                          e2h_i,
    input  logic                          mon_route_i,
    input  logic                          mon_fw_i,
    input  logic                          m_i_i,
    input  logic                          m_f_i,
    input  logic                          m_a_i,
    input  logic                          m_all_i,
    input  logic                          sp_sel_i,
    input  logic [LVLS-1:0]               nmi_en_i,
    input  logic [LVLS-1:0]               spmask_i,
    input  logic                          mode64_i,
    output logic [NUM_SRC-1:0]            ok_o
);
    localparam logic [LVL_W-1:0] LVL_ONE   = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_TWO   = LVL_W'(2);
    localparam logic [LVL_W-1:0] LVL_THREE = LVL_W'(3);

    // Decide whether source k, targeting level t, is unblocked.
    function automatic logic gate_one(input int k, input logic [LVL_W-1:0] t);
        logic all_msk, pst_ok, ovr, virt_ok;
        all_msk = nmi_en_i[t] && (cur_i == t) && (m_all_i || (spmask_i[t] && sp_sel_i));
        pst_ok  = 1'b0;
        virt_ok = 1'b0;
        ovr     = 1'b0;
        case (k)
            int'(EX_NMI):   pst_ok  = !all_msk;
            int'(EX_FIQ):   pst_ok  = !m_f_i && !all_msk;
            int'(EX_IRQ):   pst_ok  = !m_i_i && !all_msk;
            int'(EX_VNMI):  virt_ok = imo_i && !tge_i && !all_msk;
            int'(EX_VFNMI): virt_ok = fmo_i && !tge_i && !all_msk;
            int'(EX_VIRQ):  virt_ok = imo_i && !tge_i && !m_i_i && !all_msk;
            int'(EX_VFIQ):  virt_ok = fmo_i && !tge_i && !m_f_i && !all_msk;
            default:        virt_ok = amo_i && !tge_i && !m_a_i;
        endcase
        if ((t > cur_i) && (t != LVL_ONE)) begin
            if (mode64_i) begin
                ovr = (t == LVL_THREE) || ((t == LVL_TWO) && !(e2h_i && tge_i));
            end else if (k == int'(EX_FIQ)) begin
                ovr = !secure_i && (fmo_i || (mon_route_i && !(mon_fw_i && !fmo_i)));
            end else if (k == int'(EX_IRQ)) begin
                ovr = !secure_i && imo_i;
            end
        end
        if (cur_i > t) begin
            return 1'b0;
        end
        if (k == int'(EX_NMI) || k == int'(EX_FIQ) || k == int'(EX_IRQ)) begin
            return pst_ok || ovr;
        end
        return virt_ok;
    endfunction

    // Evaluate every source against its own target.
    always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
            ok_o[k] = pend_i[k] && gate_one(k, tgt_i[k]);
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority selector: the lowest set index wins. Combinational.
module irq_prio_pick
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] ok_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan from lowest priority to highest so the highest one overwrites.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (ok_i[k]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_take_arbiter.sv
// Module: irq_take_arbiter
// Top: folds, masks and prioritizes pending interrupts, then registers the
// chosen index and target with a single-cycle take flag. Assumes physical
// targets come precomputed; virtual sources always target level 1.
module irq_take_arbiter
    import irq_arb_pkg::*;
#(
    parameter int LVL_W = 2,
    localparam int LVLS = 1 << LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [LVL_W-1:0]   cur_lvl_i,
    input  logic               secure_i,
    input  logic               hv_imo_i,
    input  logic               hv_fmo_i,
    input  logic               hv_amo_i,
    input  logic               hv_tge_i,
    input  logic               hv_e2h_i,
    input  logic               mon_fiq_route_i,
    input  logic               mon_fw_i,
    input  logic               mask_irq_i,
    input  logic               mask_fiq_i,
    input  logic               mask_abt_i,
    input  logic               mask_all_i,
    input  logic               sp_sel_i,
    input  logic [LVLS-1:0]    nmi_en_i,
    input  logic [LVLS-1:0]    spmask_en_i,
    input  logic               mode64_i,
    input  logic [LVL_W-1:0]   tgt_nmi_i,
    input  logic [LVL_W-1:0]   tgt_fiq_i,
    input  logic [LVL_W-1:0]   tgt_irq_i,
    output logic               take_o,
    output logic [IDX_W-1:0]   exc_idx_o,
    output logic [LVL_W-1:0]   exc_tgt_o
);
    logic [NUM_SRC-1:0]            eff_req;
    logic [NUM_SRC-1:0]            src_ok;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_tgt;
    logic                          win_any;
    logic [IDX_W-1:0]              win_idx;

    irq_fold u_fold (
        .req_i    (req_i),
        .nmi_on_i (nmi_en_i[cur_lvl_i]),
        .eff_o    (eff_req)
    );

    // Per-source target: physical ones from inputs, virtual ones fixed at 1.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_tgt
        if (g == int'(EX_NMI)) begin : g_nmi
            assign src_tgt[g] = tgt_nmi_i;
        end else if (g == int'(EX_FIQ)) begin : g_fiq
            assign src_tgt[g] = tgt_fiq_i;
        end else if (g == int'(EX_IRQ)) begin : g_irq
            assign src_tgt[g] = tgt_irq_i;
        end else begin : g_virt
            assign src_tgt[g] = LVL_W'(1);
        end
    end

    irq_mask_eval #(.LVL_W(LVL_W)) u_mask (
        .pend_i      (eff_req),
        .tgt_i       (src_tgt),
        .cur_i       (cur_lvl_i),
        .secure_i    (secure_i),
        .imo_i       (hv_imo_i),
        .fmo_i       (hv_fmo_i),
        .amo_i       (hv_amo_i),
        .tge_i       (hv_tge_i),
        .e2h_i       (hv_e2h_i),
        .mon_route_i (mon_fiq_route_i),
        .mon_fw_i    (mon_fw_i),
        .m_i_i       (mask_irq_i),
        .m_f_i       (mask_fiq_i),
        .m_a_i       (mask_abt_i),
        .m_all_i     (mask_all_i),
        .sp_sel_i    (sp_sel_i),
        .nmi_en_i    (nmi_en_i),
        .spmask_i    (spmask_en_i),
        .mode64_i    (mode64_i),
        .ok_o        (src_ok)
    );

    irq_prio_pick u_pick (
        .ok_i  (src_ok),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    // Register the winner; hold index and target when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            exc_idx_o <= '0;
            exc_tgt_o <= '0;
        end else begin
            take_o <= win_any;
            if (win_any) begin
                exc_idx_o <= win_idx;
                exc_tgt_o <= src_tgt[win_idx];
            end
        end
    end

    assert_tgt_not_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (exc_tgt_o >= $past(cur_lvl_i)));

    assert_virt_lvl1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (exc_idx_o inside {EX_VNMI, EX_VFNMI, EX_VIRQ, EX_VFIQ, EX_VSERR}))
        |-> (exc_tgt_o == LVL_W'(1)));

    assert_vserr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_idx_o == EX_VSERR) |-> $past(hv_amo_i && !hv_tge_i));

    assert_fold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_idx_o <= EX_VFNMI) |-> $past(nmi_en_i[cur_lvl_i]));

    assert_take_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(|req_i));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> ($stable(exc_idx_o) && $stable(exc_tgt_o)));
endmodule

// File: tb/tb_irq_take_arbiter.sv
module tb_irq_take_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req;
    logic [1:0] cur;
    logic       sec, imo, fmo, amo, tge, e2h, froute, fw;
    logic       mi, mf, ma, mall, spsel, a64;
    logic [3:0] nmien, spm;
    logic [1:0] tn, tf, ti;
    logic       take;
    logic [2:0] idx;
    logic [1:0] tgt;

    always #10 clk = ~clk;

    irq_take_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cur_lvl_i(cur), .secure_i(sec),
        .hv_imo_i(imo), .hv_fmo_i(fmo), .hv_amo_i(amo), .hv_tge_i(tge), .hv_e2h_i(e2h),
        .mon_fiq_route_i(froute), .mon_fw_i(fw), .mask_irq_i(mi), .mask_fiq_i(mf),
        .mask_abt_i(ma), .mask_all_i(mall), .sp_sel_i(spsel), .nmi_en_i(nmien),
        .spmask_en_i(spm), .mode64_i(a64), .tgt_nmi_i(tn), .tgt_fiq_i(tf),
        .tgt_irq_i(ti), .take_o(take), .exc_idx_o(idx), .exc_tgt_o(tgt)
    );

    typedef struct {
        logic       tk;
        logic [2:0] ix;
        logic [1:0] tg;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [2:0] last_ix = 3'd0;
    logic [1:0] last_tg = 2'd0;

    // Bench-side rule set, written from the requirements.
    function automatic logic allowed(int k, logic [1:0] t);
        logic am, base, ovr;
        am = nmien[t] && (cur == t) && (mall || (spm[t] && spsel));
        if (cur > t) return 1'b0;
        case (k)
            1: return imo && !tge && !am;
            2: return fmo && !tge && !am;
            5: return imo && !tge && !mi && !am;
            6: return fmo && !tge && !mf && !am;
            7: return amo && !tge && !ma;
            0: base = !am;
            3: base = !mf && !am;
            default: base = !mi && !am;
        endcase
        ovr = 1'b0;
        if (t > cur && t != 2'd1) begin
            if (a64) ovr = (t == 2'd3) || !(e2h && tge);
            else if (k == 3) ovr = !sec && (fmo || (froute && !(fw && !fmo)));
            else if (k == 4) ovr = !sec && imo;
        end
        return base || ovr;
    endfunction

    function automatic logic [1:0] target_of(int k);
        if (k == 0) return tn;
        if (k == 3) return tf;
        if (k == 4) return ti;
        return 2'd1;
    endfunction

    // Driver side: compute expectation of the current inputs and queue it.
    task automatic push(string tag);
        exp_t e;
        logic [7:0] r;
        r = req;
        if (!nmien[cur]) begin
            if (r[0]) r[4] = 1'b1;
            if (r[1]) r[5] = 1'b1;
            if (r[2]) r[6] = 1'b1;
            r[2:0] = 3'b000;
        end
        e.tk = 1'b0; e.ix = last_ix; e.tg = last_tg; e.tag = tag;
        for (int k = 0; k < 8; k++) begin
            if (!e.tk && r[k] && allowed(k, target_of(k))) begin
                e.tk = 1'b1; e.ix = 3'(k); e.tg = target_of(k);
            end
        end
        last_ix = e.ix; last_tg = e.tg;
        q.push_back(e);
    endtask

    task automatic step(string tag);
        push(tag);
        @(negedge clk);
    endtask

    task automatic defaults();
        req = 8'h00; cur = 2'd1; sec = 0; imo = 0; fmo = 0; amo = 0; tge = 0; e2h = 0;
        froute = 0; fw = 0; mi = 0; mf = 0; ma = 0; mall = 0; spsel = 0; a64 = 1;
        nmien = 4'b0000; spm = 4'b0000; tn = 2'd1; tf = 2'd1; ti = 2'd1;
    endtask

    // Monitor: one result per rising edge, one register after its stimulus.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_run++;
            if (take !== e.tk || idx !== e.ix || tgt !== e.tg) begin
                n_fail++;
                $display("FAIL %s: got take=%0b idx=%0d tgt=%0d exp take=%0b idx=%0d tgt=%0d",
                         e.tag, take, idx, tgt, e.tk, e.ix, e.tg);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: got hung exp done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        n_run++;
        if (take !== 1'b0 || idx !== 3'd0 || tgt !== 2'd0) begin
            n_fail++;
            $display("FAIL R10 reset: got %0b/%0d/%0d exp 0/0/0", take, idx, tgt);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R10: plain IRQ taken, then masked by I
        req = 8'h10; step("R10 irq");
        mi = 1; step("R3 irq masked by I");
        // R11: nothing unmasked, previous values hold
        req = 8'h08; mf = 1; step("R11 hold");
        defaults();
        // R1: FIQ aimed below current level
        req = 8'h08; tf = 2'd0; step("R1 target below current");
        cur = 2'd0; step("R1 target equal current");
        // R2: all-interrupt mask forms
        defaults(); nmien = 4'b0010; req = 8'h01;
        mall = 1; step("R2 allint blocks nmi");
        mall = 0; spm = 4'b0010; spsel = 1; step("R2 sp mask blocks nmi");
        spsel = 0; step("R3 nmi taken");
        defaults(); a64 = 0; nmien = 4'b0110; mall = 1; req = 8'h01; tn = 2'd2;
        step("R2 allint idle when target above current");
        // R4: virtual routing gates
        defaults(); req = 8'h20; step("R4 virq needs imo");
        imo = 1; tge = 1; step("R4 virq refused with tge");
        tge = 0; step("R4 virq taken");
        // R5: virtual error ignores all-mask, obeys A
        defaults(); amo = 1; nmien = 4'b0010; mall = 1; req = 8'h80;
        step("R5 vserr ignores allint");
        ma = 1; step("R5 vserr masked by A");
        // R6: 64-bit override
        defaults(); mi = 1; req = 8'h10; ti = 2'd3; step("R6 target3 unmaskable");
        ti = 2'd2; e2h = 1; tge = 1; step("R6 target2 maskable with e2h tge");
        tge = 0; step("R6 target2 unmaskable");
        cur = 2'd0; ti = 2'd1; step("R6 target1 no override");
        // R7: 32-bit override
        defaults(); a64 = 0; mf = 1; req = 8'h08; tf = 2'd3; froute = 1; fw = 1;
        step("R7 fw keeps mask");
        fw = 0; step("R7 route override");
        sec = 1; step("R7 secure no override");
        sec = 0; froute = 0; fw = 1; fmo = 1; step("R7 fmo override");
        defaults(); a64 = 0; mi = 1; req = 8'h10; ti = 2'd2; imo = 1; step("R7 irq imo override");
        imo = 0; step("R7 irq masked without imo");
        // R8: priority chain
        defaults(); nmien = 4'b0010; imo = 1; fmo = 1; amo = 1; req = 8'hFF;
        step("R8 nmi first");
        mall = 1; step("R8 only vserr survives allint");
        mall = 0; req = 8'hF8; step("R8 fiq before irq");
        req = 8'h06; step("R8 vnmi before vfnmi");
        // R9: folding with feature off
        defaults(); req = 8'h01; ti = 2'd2; step("R9 nmi as irq");
        imo = 1; req = 8'h02; step("R9 vnmi as virq");
        fmo = 1; req = 8'h04; step("R9 vfnmi as vfiq");
        // R8: random sweep
        for (int n = 0; n < 400; n++) begin
            req = 8'($urandom); cur = 2'($urandom); sec = 1'($urandom);
            {imo, fmo, amo, tge, e2h, froute, fw} = 7'($urandom);
            {mi, mf, ma, mall, spsel, a64} = 6'($urandom);
            nmien = 4'($urandom); spm = 4'($urandom);
            tn = 2'($urandom); tf = 2'($urandom); ti = 2'($urandom);
            step("R8 random");
        end
        defaults();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule